// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block takes fixed-length serial frames from an external master whose bit clock is slow (nominally a few kilohertz). Both the serial clock and the serial data arrive as plain asynchronous inputs. The block pulls them into one fast system clock domain through two-flop synchronizers. The synchronized serial clock then passes through a stability filter and a rising-edge detector. No flop is ever clocked by the serial clock. Each detected rising edge is a shift enable. A bit counter picks the position in a 25-bit assembly register that receives the current data bit.

When the 25th bit arrives, the assembled word is copied to a holding output and a single-cycle valid pulse is raised in the fast domain. Two sticky diagnostic flags help find link faults. The first marks a frame broken by an idle gap, that is, a receiver waiting for a frame while its bit counter is still non-zero. The second marks serial clock rising edges that come closer together than a minimum spacing. Both flags stay set until a clear input is pulsed.

Top module: `slowlink_rx`

## Requirements
- R1: While reset is applied and after it is released, `word_out` is zero and `word_vld`, `proto_err` and `rate_err` are low until a frame or a fault occurs.
- R2: Data is sampled at filtered rising edges of the serial clock. The first bit after an idle period lands in `word_out` bit 24, and each later bit lands one position lower, down to bit 0 for the 25th.
- R3: After the 25th rising edge of a frame, `word_out` takes the assembled word and `word_vld` is high for exactly one fast clock cycle. `word_out` keeps that value until the next complete frame.
- R4: A serial clock level that lasts fewer than `FILT_LEN` fast-clock samples is ignored. It neither adds nor removes a bit.
- R5: If no rising edge arrives for `IDLE_CYC` fast cycles in the middle of a frame, the receiver returns to waiting. Because the bit counter is still non-zero in that waiting state, `proto_err` is set. No valid pulse is produced for the broken frame.
- R6: After such a timeout the bit counter restarts from zero, so the next frame is placed starting at bit 24 and decodes correctly.
- R7: `proto_err` and `rate_err` stay high until `err_clr` is asserted. `err_clr` then returns them to low.
- R8: `rate_err` is set when two filtered rising edges are fewer than `MIN_EDGE_CYC` fast cycles apart. Edges at the nominal bit period never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sck_in | input | 1 | Asynchronous serial bit clock from the master |
| sdi_in | input | 1 | Asynchronous serial data; changes on the falling edge of sck_in |
| err_clr | input | 1 | Clears both sticky error flags |
| word_out | output | FRAME_BITS | Last complete received word, first bit in the MSB |
| word_vld | output | 1 | One-cycle pulse when word_out is updated |
| proto_err | output | 1 | Sticky flag: frame broken by an idle gap |
| rate_err | output | 1 | Sticky flag: rising edges spaced too closely |

## Verification
The bench builds the receiver with a nominal bit period of 40 fast cycles. This gives an idle timeout of 80 cycles and a minimum edge spacing of 20 cycles, while the filter length stays at 4. With these values, truncated frames, timeout recovery and too-fast bursts each take a few hundred cycles rather than tens of thousands. A 10-cycle burst period still clears the 4-sample filter, so that burst decodes a word and also trips the rate flag. Two-cycle glitches sit below the filter length, so they check that short pulses are rejected.

// File: rtl/slowlink_pkg.sv
package slowlink_pkg;
  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RECV = 1'b1
  } rx_state_t;
endpackage

// File: rtl/slk_sync.sv
module slk_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g]   <= 1'b0;
        sync_out[g] <= 1'b0;
      end else begin
        meta_q[g]   <= async_in[g];
        sync_out[g] <= meta_q[g];
      end
    end
  end
endmodule

// File: rtl/slk_glitch_filter.sv
module slk_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic rise
);
  localparam int FCW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [FCW-1:0] FLAST = FCW'(FILT_LEN - 1);

  logic           lvl_q, lvl_n;
  logic [FCW-1:0] run_q, run_n;
  logic           rise_n;

  always_comb begin
    lvl_n  = lvl_q;
    run_n  = run_q;
    rise_n = 1'b0;
    if (lvl_in == lvl_q) begin
      run_n = '0;
    end else if (run_q == FLAST) begin
      lvl_n  = lvl_in;
      run_n  = '0;
      rise_n = lvl_in;
    end else begin
      run_n = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
      rise  <= 1'b0;
    end else begin
      lvl_q <= lvl_n;
      run_q <= run_n;
      rise  <= rise_n;
    end
  end

  // R4: the filtered level only moves to a value the input held
  a_r4_level_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> ($past(lvl_in) == lvl_q));
  a_r4_rise_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> lvl_q);
endmodule

// File: rtl/slk_frame_ctrl.sv
module slk_frame_ctrl
  import slowlink_pkg::*;
#(
  parameter int FRAME_BITS = 25,
  parameter int IDLE_CYC   = 80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rise,
  input  logic                  sdi,
  input  logic                  err_clr,
  output logic [FRAME_BITS-1:0] word_out,
  output logic                  word_vld,
  output logic                  proto_err
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam int TW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] CLAST = CW'(FRAME_BITS - 1);
  localparam logic [TW-1:0] TLAST = TW'(IDLE_CYC - 1);

  rx_state_t             st_q, st_n;
  logic [CW-1:0]         cnt_q, cnt_n;
  logic [TW-1:0]         tmr_q, tmr_n;
  logic [FRAME_BITS-1:0] shf_q, shf_n;
  logic [FRAME_BITS-1:0] word_n;
  logic                  vld_n;
  logic                  perr_set;

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    tmr_n    = tmr_q;
    shf_n    = shf_q;
    word_n   = word_out;
    vld_n    = 1'b0;
    perr_set = 1'b0;
    case (st_q)
      ST_WAIT: begin
        perr_set = (cnt_q != '0);
        cnt_n    = '0;
        tmr_n    = '0;
        if (rise) begin
          shf_n[FRAME_BITS-1] = sdi;
          cnt_n               = CW'(1);
          st_n                = ST_RECV;
        end
      end
      default: begin
        if (rise) begin
          tmr_n = '0;
          shf_n[CLAST - cnt_q] = sdi;
          if (cnt_q == CLAST) begin
            word_n = {shf_q[FRAME_BITS-1:1], sdi};
            vld_n  = 1'b1;
            cnt_n  = '0;
            st_n   = ST_WAIT;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end else if (tmr_q == TLAST) begin
          st_n = ST_WAIT;
        end else begin
          tmr_n = tmr_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_WAIT;
      cnt_q     <= '0;
      tmr_q     <= '0;
      shf_q     <= '0;
      word_out  <= '0;
      word_vld  <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      st_q     <= st_n;
      cnt_q    <= cnt_n;
      tmr_q    <= tmr_n;
      shf_q    <= shf_n;
      word_out <= word_n;
      word_vld <= vld_n;
      if (perr_set) begin
        proto_err <= 1'b1;
      end else if (err_clr) begin
        proto_err <= 1'b0;
      end
    end
  end

  a_r3_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);
  a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> $stable(word_out));
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CLAST);
  a_r5_perr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> $past(st_q == ST_WAIT && cnt_q != '0));
  a_r7_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err && !err_clr) |=> proto_err);
endmodule

// File: rtl/slk_rate_check.sv
module slk_rate_check #(
  parameter int MIN_EDGE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic err_clr,
  output logic rate_err
);
  localparam int RCW = $clog2(MIN_EDGE_CYC + 1);
  localparam logic [RCW-1:0] RMAX = RCW'(MIN_EDGE_CYC);
  localparam logic [RCW-1:0] RLIM = RCW'(MIN_EDGE_CYC - 1);

  logic [RCW-1:0] gap_q, gap_n;
  logic           seen_q, seen_n;
  logic           too_fast;

  always_comb begin
    too_fast = rise && seen_q && (gap_q < RLIM);
    seen_n   = seen_q | rise;
    if (rise) begin
      gap_n = '0;
    end else if (gap_q != RMAX) begin
      gap_n = gap_q + 1'b1;
    end else begin
      gap_n = gap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q    <= '0;
      seen_q   <= 1'b0;
      rate_err <= 1'b0;
    end else begin
      gap_q  <= gap_n;
      seen_q <= seen_n;
      if (too_fast) begin
        rate_err <= 1'b1;
      end else if (err_clr) begin
        rate_err <= 1'b0;
      end
    end
  end

  a_r8_rate_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rate_err) |-> $past(rise));
  a_r7_rate_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_err && !err_clr) |=> rate_err);
endmodule

// File: rtl/slowlink_rx.sv
module slowlink_rx #(
  parameter int FRAME_BITS   = 25,
  parameter int FILT_LEN     = 4,
  parameter int NOM_BIT_CYC  = 8333,
  parameter int IDLE_CYC     = 2 * NOM_BIT_CYC,
  parameter int MIN_EDGE_CYC = NOM_BIT_CYC / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck_in,
  input  logic                  sdi_in,
  input  logic                  err_clr,
  output logic [FRAME_BITS-1:0] word_out,
  output logic                  word_vld,
  output logic                  proto_err,
  output logic                  rate_err
);
  logic       rst_meta_q, rst_s_n;
  logic [1:0] pins_s;
  logic       rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  slk_sync #(.W(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .async_in ({sdi_in, sck_in}),
    .sync_out (pins_s)
  );

  slk_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .lvl_in (pins_s[0]),
    .rise   (rise)
  );

  slk_frame_ctrl #(.FRAME_BITS(FRAME_BITS), .IDLE_CYC(IDLE_CYC)) u_frame (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .rise      (rise),
    .sdi       (pins_s[1]),
    .err_clr   (err_clr),
    .word_out  (word_out),
    .word_vld  (word_vld),
    .proto_err (proto_err)
  );

  slk_rate_check #(.MIN_EDGE_CYC(MIN_EDGE_CYC)) u_rate (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .rise     (rise),
    .err_clr  (err_clr),
    .rate_err (rate_err)
  );

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_s_n |-> (!word_vld && !proto_err && !rate_err));
endmodule

// File: tb/slowlink_rx_test.sv
module slowlink_rx_test;
  localparam int FB = 25;

  logic          clk = 1'b0;
  logic          rst_n, sck_in, sdi_in, err_clr;
  logic [FB-1:0] word_out;
  logic          word_vld, proto_err, rate_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [FB-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  slowlink_rx #(.FRAME_BITS(FB), .FILT_LEN(4), .NOM_BIT_CYC(40)) uut (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .sdi_in(sdi_in),
    .err_clr(err_clr), .word_out(word_out), .word_vld(word_vld),
    .proto_err(proto_err), .rate_err(rate_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every valid pulse must match the oldest expected word
  always @(negedge clk) begin
    if (rst_n && word_vld) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R3 actual=%0h expected=none (unexpected valid)", word_out);
      end else begin
        check(tag_q.pop_front(), word_out, exp_q.pop_front());
      end
    end
  end

  task automatic send_bit(input logic b, input int half);
    @(negedge clk);
    sck_in = 1'b0;
    sdi_in = b;
    repeat (half) @(negedge clk);
    sck_in = 1'b1;
    repeat (half) @(negedge clk);
    sck_in = 1'b0;
  endtask

  // R4: data bit with a 2-cycle high spike in the low phase and a 2-cycle dip in the high phase
  task automatic send_bit_glitchy(input logic b);
    @(negedge clk);
    sck_in = 1'b0;
    sdi_in = b;
    repeat (8) @(negedge clk);
    sck_in = 1'b1;
    repeat (2) @(negedge clk);
    sck_in = 1'b0;
    repeat (10) @(negedge clk);
    sck_in = 1'b1;
    repeat (8) @(negedge clk);
    sck_in = 1'b0;
    repeat (2) @(negedge clk);
    sck_in = 1'b1;
    repeat (10) @(negedge clk);
    sck_in = 1'b0;
  endtask

  task automatic send_frame(input logic [FB-1:0] w, input int half, input bit glitch, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
    for (int i = FB - 1; i >= 0; i--) begin
      if (glitch && (i % 5 == 2)) send_bit_glitchy(w[i]);
      else send_bit(w[i], half);
    end
    repeat (30) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; sck_in = 1'b0; sdi_in = 1'b0; err_clr = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 vld in reset", word_vld, 0);
    check("R1 perr in reset", proto_err, 0);
    check("R1 rerr in reset", rate_err, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 word after reset", word_out, 0);
    check("R1 vld after reset", word_vld, 0);

    send_frame(25'h1555555, 20, 0, "R2 alternating word");
    send_frame(25'h0AAAAAA, 20, 0, "R2 inverse alternating");
    send_frame(25'h1000001, 20, 0, "R2 end bits only");
    send_frame(25'h1FFFFFF, 20, 0, "R3 all ones");
    check("R3 word held after frame", word_out, 25'h1FFFFFF);
    send_frame(25'h0000000, 20, 0, "R3 all zeros");
    check("R8 nominal spacing no rate err", rate_err, 0);
    check("R5 complete frames no proto err", proto_err, 0);

    send_frame(25'h0F0F0F3, 20, 1, "R4 glitches ignored");
    check("R4 no rate err from glitches", rate_err, 0);

    // R5: truncated frame, then idle beyond the timeout
    for (int i = 0; i < 10; i++) send_bit(1'b1, 20);
    repeat (150) @(negedge clk);
    check("R5 proto err after truncated frame", proto_err, 1);
    check("R5 word unchanged by broken frame", word_out, 25'h0F0F0F3);
    repeat (100) @(negedge clk);
    check("R7 proto err sticky", proto_err, 1);
    send_frame(25'h1234567, 20, 0, "R6 resync after timeout");
    check("R7 still set after good frame", proto_err, 1);
    pulse_clear();
    check("R7 proto err cleared", proto_err, 0);

    // R8: too-fast burst (10-cycle period < 20-cycle minimum)
    send_frame(25'h0C3A5E1, 5, 0, "R8 fast frame decodes");
    check("R8 rate err on fast edges", rate_err, 1);
    repeat (100) @(negedge clk);
    check("R7 rate err sticky", rate_err, 1);
    pulse_clear();
    check("R7 rate err cleared", rate_err, 0);
    send_frame(25'h1ABCDEF, 20, 0, "R8 nominal after clear");
    check("R8 no rate err at nominal", rate_err, 0);

    check("R3 no missing words", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule